// File: doc/BRIEF.md
# DMA Channel Request Generator

This block is the request front end of a four-channel DMA controller. For each channel it decides whether a transfer request is presented to the rest of the controller. The channel's 4-bit source select code picks one of three request origins. An internal auto request needs no outside signal. An external request arrives on an active-low pin, sampled either by level or by falling edge. A peripheral request comes from one of eight on-chip interrupt lines. The code also implies the address mode, which the block reports beside the request.

Every request is gated by four conditions. The channel enable must be set and the global DMA enable must be set. The channel's transfer-end flag and the global NMI abort flag must both be clear. The external pin passes through a two-flop synchronizer. In edge mode a detected falling edge is held pending until the channel acknowledges it or the gate closes. Undefined select codes and illegal peripheral configurations are suppressed and flagged on per-channel status outputs.

Top module: `dma_req_front`

## Requirements
- R1: A channel's `req_o` bit is 0 unless its `ch_en` bit is 1, `dma_on` is 1, its `ch_te` bit is 0 and `nmi_abort` is 0. After reset every `req_o` bit is 0.
- R2: Select code 4'b0100 (auto) raises `req_o` combinationally whenever the gate of R1 is open, with no other input needed.
- R3: Select codes 4'b0000, 4'b0010 and 4'b0011 choose the external pin. With `ch_edge`=0 (level), `req_o` is high while the synchronized pin is low. A change on `dreq_n` reaches `req_o` after the second rising clock edge.
- R4: With `ch_edge`=1, a high-to-low transition of the synchronized pin sets a pending request that drives `req_o` from the third rising edge after `dreq_n` falls. The request holds even if the pin returns high. A `ch_ack` pulse across one rising edge clears it, and it does not set again until a new falling edge.
- R5: A pending edge request is discarded at the first rising edge at which the gate of R1 is closed, so it does not reappear when the gate reopens.
- R6: `amode_o` per channel is 2 bits. Code 4'b0000 gives 0 (dual address). Code 4'b0010 gives 1 (single address, memory to device). Code 4'b0011 gives 2 (single address, device to memory). Auto and peripheral codes give 0, and undefined codes give 3.
- R7: Codes 4'b1xxx choose peripheral mode. Bits [2:0] of the code select line index k of the channel's slice `periph_req[ch*8+k]`, and `req_o` follows that line combinationally.
- R8: In peripheral mode with `ch_xfer16`=1, `req_o` stays 0 and `cfg_err_o` is 1. `ch_xfer16` has no effect in other modes.
- R9: Codes 4'b0001, 4'b0101, 4'b0110 and 4'b0111 produce no request, and `bad_mode_o` is 1.
- R10: Channels are independent: the configuration and inputs of one channel do not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_on | input | 1 | Global DMA enable |
| nmi_abort | input | 1 | Global abort flag, blocks all requests |
| ch_sel | input | 16 | Per-channel 4-bit source select codes, channel c at [4c+3:4c] |
| ch_en | input | 4 | Per-channel enable |
| ch_te | input | 4 | Per-channel transfer-end flag |
| ch_edge | input | 4 | Per-channel external detect select: 0 level, 1 falling edge |
| ch_xfer16 | input | 4 | Per-channel 16-byte transfer unit configured |
| dreq_n | input | 4 | Per-channel asynchronous active-low external request pin |
| periph_req | input | 32 | Eight peripheral request lines per channel, channel c at [8c+7:8c] |
| ch_ack | input | 4 | Per-channel acknowledge of a pending edge request |
| req_o | output | 4 | Per-channel qualified request |
| amode_o | output | 8 | Per-channel address mode, channel c at [2c+1:2c] |
| cfg_err_o | output | 4 | Peripheral mode combined with 16-byte units |
| bad_mode_o | output | 4 | Undefined select code |

## Verification
The hardest condition to reach is a pending edge request that must disappear because the gate closed for exactly one edge. That state only exists after a pin falling edge has worked its way through both synchronizer stages and the edge detector. The stimulus first produces a falling edge and waits out the three-edge latency until the request shows. It then raises the transfer-end flag, or the abort flag, across a single rising edge and drops it again. A correct design shows no request once the gate reopens, while a design that keeps the pending bit would still request.

// File: rtl/dmareq_pkg.sv
`timescale 1ns/1ps
package dmareq_pkg;

    localparam int SEL_W   = 4;
    localparam int LINE_W  = 3;
    localparam int NPER    = 1 << LINE_W;
    localparam int AMODE_W = 2;

    localparam logic [SEL_W-1:0] CODE_EXT_DUAL = 4'b0000;
    localparam logic [SEL_W-1:0] CODE_EXT_M2D  = 4'b0010;
    localparam logic [SEL_W-1:0] CODE_EXT_D2M  = 4'b0011;
    localparam logic [SEL_W-1:0] CODE_AUTO     = 4'b0100;

    typedef enum logic [AMODE_W-1:0] {
        AM_DUAL    = 2'd0,
        AM_SGL_M2D = 2'd1,
        AM_SGL_D2M = 2'd2,
        AM_NONE    = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_AUTO   = 2'd1,
        SRC_EXT    = 2'd2,
        SRC_PERIPH = 2'd3
    } src_e;

    typedef struct packed {
        src_e              src;
        amode_e            amode;
        logic [LINE_W-1:0] line;
        logic              bad;
    } sel_dec_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             te;
        logic             edge_det;
        logic             xfer16;
    } chan_cfg_t;

    function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] code);
        sel_dec_t r;
        r.src   = SRC_NONE;
        r.amode = AM_NONE;
        r.line  = code[LINE_W-1:0];
        r.bad   = 1'b0;
        if (code[SEL_W-1]) begin
            r.src   = SRC_PERIPH;
            r.amode = AM_DUAL;
        end else begin
            case (code)
                CODE_EXT_DUAL: begin r.src = SRC_EXT;  r.amode = AM_DUAL;    end
                CODE_EXT_M2D:  begin r.src = SRC_EXT;  r.amode = AM_SGL_M2D; end
                CODE_EXT_D2M:  begin r.src = SRC_EXT;  r.amode = AM_SGL_D2M; end
                CODE_AUTO:     begin r.src = SRC_AUTO; r.amode = AM_DUAL;    end
                default:       r.bad = 1'b1;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dmareq_sync.sv
`timescale 1ns/1ps
module dmareq_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= {W{RST_VAL}};
            stage2_q <= {W{RST_VAL}};
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/dmareq_chan.sv
`timescale 1ns/1ps
module dmareq_chan
    import dmareq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  chan_cfg_t       cfg,
    input  logic            dma_on,
    input  logic            nmi_abort,
    input  logic            pin_s_n,
    input  logic [NPER-1:0] periph,
    input  logic            ack,
    output logic            req,
    output amode_e          amode,
    output logic            cfg_err,
    output logic            bad_mode
);

    sel_dec_t dec;
    logic     gate;
    logic     pin_prev_q;
    logic     fall;
    logic     edge_mode;
    logic     pend_q;
    logic     pend_d;
    logic     src_hit;

    assign dec  = decode_sel(cfg.sel);
    assign gate = cfg.en & dma_on & ~cfg.te & ~nmi_abort;

    always_ff @(posedge clk) begin
        if (rst) pin_prev_q <= 1'b1;
        else     pin_prev_q <= pin_s_n;
    end

    assign fall      = pin_prev_q & ~pin_s_n;
    assign edge_mode = (dec.src == SRC_EXT) & cfg.edge_det;
    assign pend_d    = gate & edge_mode & (fall | (pend_q & ~ack));

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    always_comb begin
        case (dec.src)
            SRC_AUTO:   src_hit = 1'b1;
            SRC_EXT:    src_hit = cfg.edge_det ? pend_q : ~pin_s_n;
            SRC_PERIPH: src_hit = periph[dec.line] & ~cfg.xfer16;
            default:    src_hit = 1'b0;
        endcase
    end

    assign req      = gate & src_hit;
    assign amode    = dec.amode;
    assign cfg_err  = (dec.src == SRC_PERIPH) & cfg.xfer16;
    assign bad_mode = dec.bad;

    p_gate_drop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        !gate |=> !pend_q);

    p_pend_from_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> ($past(pin_prev_q) && !$past(pin_s_n)));

    p_ack_release_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_q && ack && !fall) |=> !pend_q);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !req);

    p_bad_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        bad_mode |-> (!req && amode == AM_NONE));

endmodule

// File: rtl/dma_req_front.sv
`timescale 1ns/1ps
module dma_req_front
    import dmareq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dma_on,
    input  logic                 nmi_abort,
    input  logic [NCH*SEL_W-1:0] ch_sel,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       ch_te,
    input  logic [NCH-1:0]       ch_edge,
    input  logic [NCH-1:0]       ch_xfer16,
    input  logic [NCH-1:0]       dreq_n,
    input  logic [NCH*NPER-1:0]  periph_req,
    input  logic [NCH-1:0]       ch_ack,
    output logic [NCH-1:0]       req_o,
    output logic [NCH*AMODE_W-1:0] amode_o,
    output logic [NCH-1:0]       cfg_err_o,
    output logic [NCH-1:0]       bad_mode_o
);

    logic [NCH-1:0] pin_s_n;

    dmareq_sync #(.W(NCH), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (dreq_n),
        .q   (pin_s_n)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t cfg;
        amode_e    am;

        assign cfg.sel      = ch_sel[c*SEL_W +: SEL_W];
        assign cfg.en       = ch_en[c];
        assign cfg.te       = ch_te[c];
        assign cfg.edge_det = ch_edge[c];
        assign cfg.xfer16   = ch_xfer16[c];

        dmareq_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg),
            .dma_on    (dma_on),
            .nmi_abort (nmi_abort),
            .pin_s_n   (pin_s_n[c]),
            .periph    (periph_req[c*NPER +: NPER]),
            .ack       (ch_ack[c]),
            .req       (req_o[c]),
            .amode     (am),
            .cfg_err   (cfg_err_o[c]),
            .bad_mode  (bad_mode_o[c])
        );

        assign amode_o[c*AMODE_W +: AMODE_W] = am;
    end

    p_global_gate_r1: assert property (@(posedge clk) disable iff (rst)
        (|req_o) |-> (dma_on && !nmi_abort));

    p_chan_gate_r1: assert property (@(posedge clk) disable iff (rst)
        ((req_o & ~ch_en) == '0) && ((req_o & ch_te) == '0));

endmodule

// File: tb/sim_dma_req_front.sv
`timescale 1ns/1ps
module sim_dma_req_front;

    localparam int NCH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dma_on = 1'b0;
    logic          nmi_abort = 1'b0;
    logic [15:0]   ch_sel = '0;
    logic [3:0]    ch_en = '0;
    logic [3:0]    ch_te = '0;
    logic [3:0]    ch_edge = '0;
    logic [3:0]    ch_xfer16 = '0;
    logic [3:0]    dreq_n = '1;
    logic [31:0]   periph_req = '0;
    logic [3:0]    ch_ack = '0;
    logic [3:0]    req_o;
    logic [7:0]    amode_o;
    logic [3:0]    cfg_err_o;
    logic [3:0]    bad_mode_o;

    always #2.5 clk = ~clk;

    dma_req_front #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .dma_on(dma_on), .nmi_abort(nmi_abort),
        .ch_sel(ch_sel), .ch_en(ch_en), .ch_te(ch_te), .ch_edge(ch_edge),
        .ch_xfer16(ch_xfer16), .dreq_n(dreq_n), .periph_req(periph_req),
        .ch_ack(ch_ack), .req_o(req_o), .amode_o(amode_o),
        .cfg_err_o(cfg_err_o), .bad_mode_o(bad_mode_o)
    );

    typedef struct {
        int    ch;
        bit    rq;
        int    md;
        bit    er;
        bit    bd;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic expect_ch(input int ch, input bit rq, input int md,
                             input bit er, input bit bd, input string tag);
        exp_t e;
        e.ch = ch; e.rq = rq; e.md = md; e.er = er; e.bd = bd; e.tag = tag;
        sbq.push_back(e);
        #0.1;
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            int   act_md;
            wait (sbq.size() != 0);
            e = sbq.pop_front();
            act_md = int'(amode_o[e.ch*2 +: 2]);
            n_vec++;
            if (req_o[e.ch] !== e.rq || act_md != e.md ||
                cfg_err_o[e.ch] !== e.er || bad_mode_o[e.ch] !== e.bd) begin
                n_fail++;
                $display("FAIL %s ch%0d: actual req=%0b mode=%0d err=%0b bad=%0b expected req=%0b mode=%0d err=%0b bad=%0b",
                         e.tag, e.ch, req_o[e.ch], act_md, cfg_err_o[e.ch],
                         bad_mode_o[e.ch], e.rq, e.md, e.er, e.bd);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic finish_run();
        #1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        done = 1'b1;
        $finish;
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still going expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : driver
        step(3);
        rst = 1'b0;
        settle();
        for (int c = 0; c < NCH; c++) expect_ch(c, 0, 0, 0, 0, "R1 reset");

        // R2 auto request on channel 0
        dma_on = 1'b1;
        ch_sel[3:0] = 4'b0100;
        ch_en[0] = 1'b1;
        settle();
        expect_ch(0, 1, 0, 0, 0, "R2 auto");
        expect_ch(1, 0, 0, 0, 0, "R1 disabled channel");

        // R1 each gate condition
        dma_on = 1'b0; settle();
        expect_ch(0, 0, 0, 0, 0, "R1 global off");
        dma_on = 1'b1; ch_te[0] = 1'b1; settle();
        expect_ch(0, 0, 0, 0, 0, "R1 transfer end");
        ch_te[0] = 1'b0; nmi_abort = 1'b1; settle();
        expect_ch(0, 0, 0, 0, 0, "R1 abort");
        nmi_abort = 1'b0; ch_en[0] = 1'b0; settle();
        expect_ch(0, 0, 0, 0, 0, "R1 channel off");
        ch_en[0] = 1'b1; settle();
        expect_ch(0, 1, 0, 0, 0, "R2 auto reopened");

        // R3 level detect on channel 1
        step(1);
        ch_sel[7:4] = 4'b0000; ch_edge[1] = 1'b0; ch_en[1] = 1'b1;
        dreq_n[1] = 1'b0;
        settle();
        expect_ch(1, 0, 0, 0, 0, "R3 before sync");
        step(1);
        expect_ch(1, 0, 0, 0, 0, "R3 one stage");
        step(1);
        expect_ch(1, 1, 0, 0, 0, "R3 level low");
        dreq_n[1] = 1'b1;
        step(1);
        expect_ch(1, 1, 0, 0, 0, "R3 still in sync");
        step(1);
        expect_ch(1, 0, 0, 0, 0, "R3 level released");

        // R4 edge detect on channel 2
        ch_sel[11:8] = 4'b0010; ch_edge[2] = 1'b1; ch_en[2] = 1'b1;
        settle();
        expect_ch(2, 0, 1, 0, 0, "R6 single m2d");
        dreq_n[2] = 1'b0;
        step(2);
        expect_ch(2, 0, 1, 0, 0, "R4 edge not yet latched");
        step(1);
        expect_ch(2, 1, 1, 0, 0, "R4 edge latched");
        step(3);
        expect_ch(2, 1, 1, 0, 0, "R4 held");
        ch_ack[2] = 1'b1;
        step(1);
        ch_ack[2] = 1'b0;
        settle();
        expect_ch(2, 0, 1, 0, 0, "R4 ack clears");
        step(3);
        expect_ch(2, 0, 1, 0, 0, "R4 no retrigger on level");
        dreq_n[2] = 1'b1;
        step(3);
        expect_ch(2, 0, 1, 0, 0, "R4 rising edge ignored");
        dreq_n[2] = 1'b0;
        step(3);
        expect_ch(2, 1, 1, 0, 0, "R4 second edge");
        dreq_n[2] = 1'b1;
        step(3);
        expect_ch(2, 1, 1, 0, 0, "R4 held after pin high");

        // R5 gate drop discards pending
        ch_te[2] = 1'b1; settle();
        expect_ch(2, 0, 1, 0, 0, "R1 te gates pending");
        step(1);
        ch_te[2] = 1'b0; settle();
        expect_ch(2, 0, 1, 0, 0, "R5 te discards pending");
        dreq_n[2] = 1'b0;
        step(3);
        expect_ch(2, 1, 1, 0, 0, "R4 third edge");
        nmi_abort = 1'b1;
        step(1);
        nmi_abort = 1'b0; settle();
        expect_ch(2, 0, 1, 0, 0, "R5 abort discards pending");
        expect_ch(0, 1, 0, 0, 0, "R10 auto back after abort");

        // R6 address modes on channel 3
        ch_en[3] = 1'b1;
        ch_sel[15:12] = 4'b0011; settle();
        expect_ch(3, 0, 2, 0, 0, "R6 single d2m");
        ch_sel[15:12] = 4'b0000; settle();
        expect_ch(3, 0, 0, 0, 0, "R6 dual ext");
        ch_sel[15:12] = 4'b0100; ch_xfer16[3] = 1'b1; settle();
        expect_ch(3, 1, 0, 0, 0, "R8 xfer16 no effect on auto");
        ch_xfer16[3] = 1'b0;

        // R7 peripheral line select
        ch_sel[15:12] = 4'b1101; settle();
        expect_ch(3, 0, 0, 0, 0, "R7 line idle");
        periph_req[3*8 + 5] = 1'b1; settle();
        expect_ch(3, 1, 0, 0, 0, "R7 line5 active");
        expect_ch(2, 0, 1, 0, 0, "R10 other channel unaffected");
        periph_req[3*8 + 5] = 1'b0; periph_req[3*8 + 4] = 1'b1; settle();
        expect_ch(3, 0, 0, 0, 0, "R7 wrong line");
        ch_sel[15:12] = 4'b1000; periph_req[3*8 + 0] = 1'b1; settle();
        expect_ch(3, 1, 0, 0, 0, "R7 line0 active");

        // R8 peripheral with 16-byte units
        ch_xfer16[3] = 1'b1; settle();
        expect_ch(3, 0, 0, 1, 0, "R8 illegal config");
        ch_xfer16[3] = 1'b0;

        // R9 undefined codes
        ch_sel[15:12] = 4'b0001; settle();
        expect_ch(3, 0, 3, 0, 1, "R9 code 0001");
        ch_sel[15:12] = 4'b0101; settle();
        expect_ch(3, 0, 3, 0, 1, "R9 code 0101");
        ch_sel[15:12] = 4'b0110; settle();
        expect_ch(3, 0, 3, 0, 1, "R9 code 0110");
        ch_sel[15:12] = 4'b0111; settle();
        expect_ch(3, 0, 3, 0, 1, "R9 code 0111");
        expect_ch(0, 1, 0, 0, 0, "R10 auto unaffected by neighbour");

        step(1);
        finish_run();
    end

endmodule